// File: doc/BRIEF.md
# Three-wire clock and parameter-RAM controller

This block is the serial side of a small timekeeping device. A host reaches it over three lines: an active-low select, a serial clock and a data line. The data line is carried as a separate input, output and output-enable. The device keeps a free-running seconds count and a bank of parameter RAM split into sectors of 32 bytes. A write-protect flag can lock the RAM and the other writable registers against stray writes.

Every transaction opens with a command byte. The command byte carries the read/write direction in bit 7, a register class and an address. The decoded class sets the length of the transaction:
- A short read returns one data byte straight after the command.
- A register write takes one data byte.
- An extended access takes an address byte. A read then returns data, and a write takes a third byte that holds the data.

Raising the select line at any point abandons the transaction. A one-pulse-per-second strobe advances the seconds count, and a side port can preload it.

Top module: `rtcp_top`

## Requirements
- R1: While `ce_n` is high, edges on `sclk` and values on `sdi` have no effect on any state, and `sdo_oe` is low from the cycle after `ce_n` is seen high.
- R2: With `ce_n` low and no read in progress, one bit of `sdi` is taken on each rising `sclk` edge, MSB first, and eight bits make one byte.
- R3: After a read command, `sdo_oe` goes high and the eight data bits appear on `sdo`, MSB first. Each bit appears on a falling `sclk` edge. `sdo` changes only on a falling edge. `sdo_oe` drops on the rising edge that follows the eighth falling edge, and that rising edge is not taken as input.
- R4: Command `{rd,0,0,0,n1,n0,0,1}` selects seconds byte n, where byte 0 is the least significant. A read (rd=1) returns that byte as it stood when the command completed.
- R5: Command `{rd,1,a3,a2,a1,a0,0,1}` selects RAM address 0x00 to 0x0F. A write (rd=0) stores the next byte there, and a read returns the stored byte.
- R6: Command `{rd,0,1,0,a1,a0,0,1}` selects RAM address 0x10 to 0x13 in the same array as R5 and R7.
- R7: Command `{rd,0,1,1,1,s2,s1,s0}` is extended access to sector s. Bits 6:2 of the next byte give the address within the sector, and the RAM index is s*32 plus that address. A read then returns that byte. A write stores the third byte there.
- R8: Write 0x35 followed by a byte loads the protect flag from bit 7 of that byte. While the flag is set, every other write command is dropped and leaves the RAM unchanged. Reads still work while the flag is set.
- R9: A write of 0x31 (test register) or a write to a seconds byte is accepted and discarded. Undecodable bytes are dropped, and the byte after them is taken as a new command. Bytes with bits 1:0 other than 01 outside the extended pattern are undecodable, as are 0xB1 and 0xB5.
- R10: A high `sec_load` copies `sec_value` into the seconds count and takes priority over `pps`. Otherwise a high `pps` adds one, wrapping at the top of the range.
- R11: Raising `ce_n` in the middle of a command, argument or read returns the block to waiting for a command. Any partial byte is discarded.
- R12: After reset the protect flag is clear, the seconds count and every RAM byte are zero, and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | High while the block drives the data line |
| pps | input | 1 | One-pulse-per-second strobe |
| sec_load | input | 1 | Preload strobe for the seconds count |
| sec_value | input | SEC_W | Preload value |

## Verification
The bench builds the block with its default 32-bit seconds count and 256-byte RAM, which is exactly the space the command byte can address. With those sizes the top RAM index 255 (sector 7, address 31) can be reached. The wrap of an all-ones seconds count can be read byte by byte. The two short-form address ranges can be cross-checked against the extended path into the same array. The bench also exercises the protect flag, aborts at every phase of a transaction, and undecodable commands followed by valid ones in the same transaction.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_SECS,
        K_TEST,
        K_WPROT,
        K_RAM,
        K_EXT
    } kind_e;

    typedef struct packed {
        logic       rd;
        kind_e      kind;
        logic [4:0] idx;
    } cmd_t;

    typedef enum logic [1:0] {
        Q_CMD,
        Q_ARG,
        Q_DATA
    } phase_e;

    // Classify a command byte; idx carries seconds byte, RAM address or sector.
    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t       c;
        logic [4:0] u;
        c.rd   = b[7];
        c.kind = K_NONE;
        c.idx  = '0;
        u      = b[6:2];
        if (b[6:3] == 4'b0111) begin
            c.kind = K_EXT;
            c.idx  = {2'b00, b[2:0]};
        end else if (b[1:0] == 2'b01) begin
            if (u[4:2] == 3'b000) begin
                c.kind = K_SECS;
                c.idx  = {3'b000, u[1:0]};
            end else if (u == 5'h0c) begin
                if (!c.rd) c.kind = K_TEST;
            end else if (u == 5'h0d) begin
                if (!c.rd) c.kind = K_WPROT;
            end else if (u[4:2] == 3'b010) begin
                c.kind = K_RAM;
                c.idx  = {3'b100, u[1:0]};
            end else if (u[4]) begin
                c.kind = K_RAM;
                c.idx  = {1'b0, u[3:0]};
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] ext_index(input logic [2:0] sector, input logic [7:0] arg);
        return {sector, arg[6:2]};
    endfunction

endpackage

// File: rtl/rtcp_serdes.sv
module rtcp_serdes #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic              sclk_q;
    logic              rise;
    logic              fall;
    logic              busy;
    logic [CW-1:0]     rx_cnt;
    logic [CW-1:0]     tx_left;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign rise   = !ce_n && sclk && !sclk_q;
    assign fall   = !ce_n && !sclk && sclk_q;
    assign sdo_oe = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b1;
            rx_cnt   <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            busy     <= 1'b0;
            tx_left  <= '0;
            tx_sh    <= '0;
            sdo      <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            rx_valid <= 1'b0;
            if (ce_n) begin
                rx_cnt  <= '0;
                busy    <= 1'b0;
                tx_left <= '0;
            end else if (tx_load) begin
                busy    <= 1'b1;
                tx_sh   <= tx_byte;
                tx_left <= CW'(BYTE_W);
            end else if (busy) begin
                if (fall && tx_left != '0) begin
                    sdo     <= tx_sh[BYTE_W-1];
                    tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                    tx_left <= tx_left - 1'b1;
                end else if (rise && tx_left == '0) begin
                    busy <= 1'b0;
                end
            end else if (rise) begin
                if (rx_cnt == CW'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, sdi};
                    rx_cnt   <= '0;
                end else begin
                    rx_cnt <= rx_cnt + 1'b1;
                end
                rx_sh <= {rx_sh[BYTE_W-3:0], sdi};
            end
        end
    end
endmodule

// File: rtl/rtcp_secs.sv
module rtcp_secs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/rtcp_pram.sv
module rtcp_pram #(
    parameter int DEPTH = 256,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/rtcp_top.sv
module rtcp_top
    import rtcp_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int PRAM_DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             pps,
    input  logic             sec_load,
    input  logic [SEC_W-1:0] sec_value
);
    localparam int AW = $clog2(PRAM_DEPTH);

    logic             rx_valid;
    logic [7:0]       rx_byte;
    logic             tx_load;
    logic [7:0]       tx_byte;
    logic [SEC_W-1:0] seconds;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [AW-1:0]    ram_raddr;
    logic [7:0]       ram_wdata;
    logic [7:0]       ram_rdata;
    logic             act;
    cmd_t             dec;
    cmd_t             cur;
    phase_e           phase;
    logic [AW-1:0]    ext_addr;
    logic             wp;

    rtcp_serdes #(.BYTE_W(8)) u_serdes (
        .clk(clk), .rst(rst), .ce_n(ce_n), .sclk(sclk), .sdi(sdi),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    rtcp_secs #(.W(SEC_W)) u_secs (
        .clk(clk), .rst(rst), .tick(pps), .load(sec_load),
        .load_val(sec_value), .count(seconds)
    );

    rtcp_pram #(.DEPTH(PRAM_DEPTH), .DW(8)) u_pram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_waddr),
        .wdata(ram_wdata), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    assign act = rx_valid && !ce_n;
    assign dec = decode_cmd(rx_byte);

    always_comb begin
        tx_load   = 1'b0;
        tx_byte   = '0;
        ram_we    = 1'b0;
        ram_waddr = '0;
        ram_wdata = rx_byte;
        ram_raddr = '0;
        if (act) begin
            case (phase)
                Q_CMD: begin
                    if (dec.rd && dec.kind == K_SECS) begin
                        tx_load = 1'b1;
                        tx_byte = seconds[{dec.idx[1:0], 3'b000} +: 8];
                    end else if (dec.rd && dec.kind == K_RAM) begin
                        ram_raddr = AW'(dec.idx);
                        tx_load   = 1'b1;
                        tx_byte   = ram_rdata;
                    end
                end
                Q_ARG: begin
                    if (cur.kind == K_EXT && cur.rd) begin
                        ram_raddr = AW'(ext_index(cur.idx[2:0], rx_byte));
                        tx_load   = 1'b1;
                        tx_byte   = ram_rdata;
                    end else if (cur.kind == K_RAM) begin
                        ram_we    = 1'b1;
                        ram_waddr = AW'(cur.idx);
                    end
                end
                Q_DATA: begin
                    ram_we    = 1'b1;
                    ram_waddr = ext_addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= Q_CMD;
            cur      <= '0;
            ext_addr <= '0;
            wp       <= 1'b0;
        end else if (ce_n) begin
            phase <= Q_CMD;
        end else if (act) begin
            case (phase)
                Q_CMD: begin
                    if (dec.kind == K_EXT && (dec.rd || !wp)) begin
                        phase <= Q_ARG;
                        cur   <= dec;
                    end else if (dec.kind != K_NONE && dec.kind != K_EXT && !dec.rd
                                 && (dec.kind == K_WPROT || !wp)) begin
                        phase <= Q_ARG;
                        cur   <= dec;
                    end
                end
                Q_ARG: begin
                    if (cur.kind == K_WPROT) wp <= rx_byte[7];
                    if (cur.kind == K_EXT && !cur.rd) begin
                        ext_addr <= AW'(ext_index(cur.idx[2:0], rx_byte));
                        phase    <= Q_DATA;
                    end else begin
                        phase <= Q_CMD;
                    end
                end
                default: phase <= Q_CMD;
            endcase
        end
    end
endmodule

// File: rtl/rtcp_chk.sv
module rtcp_chk #(
    parameter int SEC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ce_n,
    input logic             sclk,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             pps,
    input logic             sec_load,
    input logic [SEC_W-1:0] sec_value,
    input logic [SEC_W-1:0] seconds,
    input logic             wp,
    input logic             ram_we
);
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !sdo_oe);

    a_r3_sdo_moves_on_edge_only: assert property (@(posedge clk) disable iff (rst)
        (sclk == $past(sclk)) |=> $stable(sdo));

    a_r10_preload: assert property (@(posedge clk) disable iff (rst)
        sec_load |=> seconds == $past(sec_value));

    a_r10_tick: assert property (@(posedge clk) disable iff (rst)
        (pps && !sec_load) |=> seconds == SEC_W'($past(seconds) + 1'b1));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!pps && !sec_load) |=> $stable(seconds));

    a_r8_protect_blocks_ram: assert property (@(posedge clk) disable iff (rst)
        wp |-> !ram_we);
endmodule

bind rtcp_top rtcp_chk #(.SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
    .pps(pps), .sec_load(sec_load), .sec_value(sec_value), .seconds(seconds),
    .wp(wp), .ram_we(ram_we)
);

// File: tb/sim_rtcp_top.sv
module sim_rtcp_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        pps = 1'b0;
    logic        sec_load = 1'b0;
    logic [31:0] sec_value = '0;
    logic        sdo;
    logic        sdo_oe;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [7:0]  m_ram [256];
    logic [31:0] m_sec;
    logic        m_wp;

    rtcp_top u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .pps(pps), .sec_load(sec_load),
        .sec_value(sec_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_t();
        @(negedge clk) ce_n = 1'b0;
        idle(2);
    endtask

    task automatic close_t();
        @(negedge clk) begin ce_n = 1'b1; sclk = 1'b1; end
        idle(3);
    endtask

    task automatic put_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk) begin sclk = 1'b0; sdi = b[i]; end
            idle(HALF);
            @(negedge clk) sclk = 1'b1;
            idle(HALF);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        put_bits(b, 8);
    endtask

    task automatic get_byte(output logic [7:0] b);
        logic oe_ok;
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) sclk = 1'b0;
            idle(HALF);
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            b[i] = sdo;
            @(negedge clk) sclk = 1'b1;
            idle(HALF);
        end
        check("R3 output enable held for eight bits", {31'b0, oe_ok}, 32'd1);
        check("R3 output enable released", {31'b0, sdo_oe}, 32'd0);
    endtask

    function automatic logic [7:0] ram_cmd(input int a, input logic rd);
        if (a < 16) return {rd, 1'b1, 4'(a), 2'b01};
        return {rd, 3'b010, 2'(a), 2'b01};
    endfunction

    task automatic read_one(input string req, input logic [7:0] cmd, input logic [7:0] exp);
        logic [7:0] b;
        open_t();
        put_byte(cmd);
        get_byte(b);
        close_t();
        check(req, {24'b0, b}, {24'b0, exp});
    endtask

    task automatic write_ram(input int a, input logic [7:0] d);
        open_t();
        put_byte(ram_cmd(a, 1'b0));
        put_byte(d);
        close_t();
        if (!m_wp) m_ram[a] = d;
    endtask

    task automatic ext_write(input int sec, input int a, input logic [7:0] d);
        open_t();
        put_byte({1'b0, 4'b0111, 3'(sec)});
        put_byte({1'b0, 5'(a), 2'b00});
        put_byte(d);
        close_t();
        if (!m_wp) m_ram[sec*32 + a] = d;
    endtask

    task automatic ext_read(input string req, input int sec, input int a);
        logic [7:0] b;
        open_t();
        put_byte({1'b1, 4'b0111, 3'(sec)});
        put_byte({1'b0, 5'(a), 2'b00});
        get_byte(b);
        close_t();
        check(req, {24'b0, b}, {24'b0, m_ram[sec*32 + a]});
    endtask

    task automatic set_wp(input logic [7:0] d);
        open_t();
        put_byte(8'h35);
        put_byte(d);
        close_t();
        m_wp = d[7];
    endtask

    task automatic tick();
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
        m_sec = m_sec + 1;
    endtask

    task automatic preload(input logic [31:0] v, input logic with_pps);
        @(negedge clk) begin sec_load = 1'b1; sec_value = v; pps = with_pps; end
        @(negedge clk) begin sec_load = 1'b0; pps = 1'b0; end
        m_sec = v;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] b;
        for (int i = 0; i < 256; i++) m_ram[i] = 8'h00;
        m_sec = '0;
        m_wp  = 1'b0;
        idle(4);
        @(negedge clk) rst = 1'b0;
        idle(2);

        // R12 reset state
        check("R12 sdo_oe after reset", {31'b0, sdo_oe}, 32'd0);
        read_one("R12 seconds zero after reset", 8'h81, 8'h00);
        read_one("R12 RAM zero after reset", ram_cmd(5, 1'b1), 8'h00);

        // R10 counting and preload, R4 byte order
        tick(); tick(); tick();
        read_one("R10 three pulses counted", 8'h81, m_sec[7:0]);
        preload(32'h12345678, 1'b0);
        for (int n = 0; n < 4; n++)
            read_one("R4 seconds byte select", 8'h81 | 8'(n << 2), m_sec[8*n +: 8]);
        preload(32'hFFFFFFFF, 1'b1);
        read_one("R10 preload wins over pulse", 8'h8D, 8'hFF);
        tick();
        read_one("R10 wrap low byte", 8'h81, 8'h00);
        read_one("R10 wrap high byte", 8'h8D, 8'h00);

        // R5, R2 low RAM range
        write_ram(3, 8'hA5);
        write_ram(15, 8'h5A);
        read_one("R5 RAM 0x03", ram_cmd(3, 1'b1), m_ram[3]);
        read_one("R5 RAM 0x0F", ram_cmd(15, 1'b1), m_ram[15]);
        // R6 high RAM range
        write_ram(18, 8'h3C);
        read_one("R6 RAM 0x12", ram_cmd(18, 1'b1), m_ram[18]);
        ext_read("R6 shared array via extended path", 0, 18);

        // R7 extended access
        ext_write(5, 17, 8'h77);
        ext_read("R7 sector 5 address 17", 5, 17);
        ext_write(7, 31, 8'hE1);
        ext_read("R7 top index 255", 7, 31);
        ext_read("R7 neighbour untouched", 7, 30);

        // R1 deselected traffic ignored
        @(negedge clk) ce_n = 1'b1;
        put_byte(ram_cmd(3, 1'b0));
        put_byte(8'h00);
        check("R1 no drive while deselected", {31'b0, sdo_oe}, 32'd0);
        read_one("R1 RAM untouched while deselected", ram_cmd(3, 1'b1), m_ram[3]);

        // R11 aborts
        open_t();
        put_bits(ram_cmd(3, 1'b0), 4);
        close_t();
        read_one("R11 abort in command byte", ram_cmd(3, 1'b1), m_ram[3]);
        open_t();
        put_byte(ram_cmd(3, 1'b0));
        put_bits(8'h00, 5);
        close_t();
        read_one("R11 abort in argument byte", ram_cmd(3, 1'b1), m_ram[3]);
        open_t();
        put_byte(ram_cmd(3, 1'b1));
        put_bits(8'h00, 3);
        @(negedge clk) ce_n = 1'b1;
        idle(2);
        check("R11 abort during read releases line", {31'b0, sdo_oe}, 32'd0);
        @(negedge clk) sclk = 1'b1;
        idle(3);
        read_one("R11 read after aborted read", ram_cmd(15, 1'b1), m_ram[15]);

        // R8 write protect
        set_wp(8'h80);
        write_ram(3, 8'h11);
        ext_write(5, 17, 8'h22);
        read_one("R8 protected short write dropped", ram_cmd(3, 1'b1), m_ram[3]);
        ext_read("R8 protected extended write dropped", 5, 17);
        set_wp(8'h7F);
        write_ram(3, 8'h11);
        read_one("R8 write after protect cleared", ram_cmd(3, 1'b1), m_ram[3]);

        // R9 discarded and undecodable commands
        open_t(); put_byte(8'h31); put_byte(8'hFF); close_t();
        open_t(); put_byte(8'h01); put_byte(8'hAA); close_t();
        read_one("R9 seconds write discarded", 8'h81, m_sec[7:0]);
        write_ram(4, 8'h44);
        read_one("R9 test write leaves RAM writable", ram_cmd(4, 1'b1), m_ram[4]);
        open_t();
        put_byte(8'hB5);
        put_byte(8'h00);
        put_byte(ram_cmd(4, 1'b1));
        get_byte(b);
        close_t();
        check("R9 undecodable bytes dropped", {24'b0, b}, {24'b0, m_ram[4]});
        open_t();
        put_byte(8'hB1);
        put_byte(8'h85);
        get_byte(b);
        close_t();
        check("R9 read of test register dropped", {24'b0, b}, {24'b0, m_sec[15:8]});

        summary();
        $finish;
    end
endmodule